// File: doc/BRIEF.md
# Cascaded Serial DAC Host Controller

This block is the host-side master for a chain of NDEV serial DACs with 16-bit words. The data output of each device feeds the data input of the next. One start pulse launches a complete burst. The controller drops the frame strobe `sync_n`, emits exactly 16·NDEV falling edges on `sclk` and shifts the whole `wr_data` vector out on `sdin`. It orders the bits so that every word finishes in its own device.

During the same burst the controller samples the serial output of the far device. That stream holds the previous register contents of every device in turn, and the controller rebuilds it into `rd_data`. After the frame closes it waits a guard gap and then pulses the load strobe `ldac_n`, so that all outputs change at once.

The SCLK half period, in system clocks, is the parameter DIV. The chain length is NDEV.

Top module: `dac_chain_host`

## Requirements
- R1: After reset, `sync_n`, `ldac_n` and `sclk` are high, and `busy` and `done` are low.
- R2: `sclk` rests high whenever `sync_n` is high. Each burst produces exactly 16·NDEV falling edges of `sclk` while `sync_n` is low.
- R3: Device 0 is driven directly by `sdin`, and device NDEV-1 drives `sdo`. After a burst, device i holds `wr_data[16i+15:16i]`. The word for device NDEV-1 goes out first, and each word goes out MSB first.
- R4: `sdin` changes only when `sclk` rises and never while `sclk` is low, so it is stable at every falling edge.
- R5: `sdo` is sampled at each falling edge. At the end of a burst, `rd_data[16i+15:16i]` equals the register content that device i held before that burst.
- R6: `sync_n` rises only after the last rising edge of `sclk`. It then stays high for at least two SCLK periods (4·DIV clocks) before `ldac_n` falls.
- R7: `ldac_n` goes low once per burst, for exactly two SCLK periods (4·DIV clocks), and only while `sync_n` is high.
- R8: `busy` is high from the cycle after an accepted start until `ldac_n` returns high. `done` pulses for one cycle, in the same cycle that `busy` falls.
- R9: A start pulse received while `busy` is high is ignored. The running burst is unchanged and no second burst follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to run a burst |
| wr_data | input | 16·NDEV | Word i, bits [16i+15:16i], is destined for device i |
| rd_data | output | 16·NDEV | Word i holds the readback of device i from the last burst |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse at the end of the sequence |
| sclk | output | 1 | Serial clock to all devices |
| sync_n | output | 1 | Active-low frame strobe to all devices |
| sdin | output | 1 | Serial data to device 0 |
| sdo | input | 1 | Serial data from device NDEV-1 |
| ldac_n | output | 1 | Active-low load strobe to all devices |

## Verification
Several properties are checked on every cycle:
- `ldac_n` never goes low while the frame is open.
- `sclk` rests high outside a frame.
- `sdin` holds steady across every falling edge.
- `sync_n` rises only with `sclk` high and the full edge count reached.
- `done` lasts one cycle and coincides with `busy` falling.

Other behaviours only the bench's scenarios can show, because they depend on the contents of the chain. These are the landing of each word in the right device, the readback order, the exact edge count, the guard and strobe widths, and the rejection of a start that arrives mid-burst. The bench shows them against a cycle model of three cascaded shift-register devices.

// File: rtl/dac_chain_host.sv
module dac_chain_host #(
  parameter int NDEV  = 3,
  parameter int WBITS = 16,
  parameter int DIV   = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [NDEV*WBITS-1:0] wr_data,
  output logic [NDEV*WBITS-1:0] rd_data,
  output logic                  busy,
  output logic                  done,
  output logic                  sclk,
  output logic                  sync_n,
  output logic                  sdin,
  input  logic                  sdo,
  output logic                  ldac_n
);
  localparam int TOT = NDEV * WBITS;
  localparam int FW  = $clog2(TOT + 1);
  localparam int DW  = $clog2(DIV + 1);

  typedef enum logic [2:0] {IDLE, SETUP, SHIFT, GAP, STROBE} st_t;

  st_t            st;
  logic [DW-1:0]  dcnt;
  logic [FW-1:0]  fc;
  logic [1:0]     hcnt;
  logic [TOT-1:0] sh, cap;

  wire tick = (dcnt == DW'(DIV - 1));

  assign busy   = (st != IDLE);
  assign sync_n = !(st == SETUP || st == SHIFT);
  assign ldac_n = (st != STROBE);
  assign sdin   = sh[TOT-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= IDLE;
      dcnt    <= '0;
      fc      <= '0;
      hcnt    <= '0;
      sh      <= '0;
      cap     <= '0;
      rd_data <= '0;
      sclk    <= 1'b1;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      dcnt <= (st == IDLE || tick) ? '0 : dcnt + 1'b1;
      case (st)
        IDLE: if (start) begin
          st   <= SETUP;
          sh   <= wr_data;
          fc   <= '0;
          hcnt <= '0;
        end
        SETUP: if (tick) st <= SHIFT;
        SHIFT: if (tick) begin
          sclk <= !sclk;
          if (sclk) begin
            cap <= {cap[TOT-2:0], sdo};
            fc  <= fc + 1'b1;
          end else if (fc == FW'(TOT)) begin
            st      <= GAP;
            rd_data <= cap;
          end else begin
            sh <= {sh[TOT-2:0], 1'b0};
          end
        end
        GAP: if (tick) begin
          hcnt <= hcnt + 1'b1;
          if (hcnt == 2'd3) st <= STROBE;
        end
        STROBE: if (tick) begin
          hcnt <= hcnt + 1'b1;
          if (hcnt == 2'd3) begin
            st   <= IDLE;
            done <= 1'b1;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  // R7
  ldac_closed_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ldac_n |-> sync_n);

  // R2
  sclk_rest_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_n |-> sclk);

  // R4
  sdin_steady_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> $stable(sdin));

  // R6
  frame_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_n) |-> (sclk && fc == FW'(TOT)));

  // R8
  done_with_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/dac_chain_host_bench.sv
`timescale 1ns/1ps
module dac_chain_host_bench;
  localparam int N = 3, W = 16, DIV = 2, TOT = N * W;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [TOT-1:0] wr_data = '0;
  logic [TOT-1:0] rd_data;
  logic busy, done, sclk, sync_n, sdin, sdo, ldac_n;

  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  dac_chain_host #(.NDEV(N), .WBITS(W), .DIV(DIV)) u_dac_chain_host (
    .clk(clk), .rst_n(rst_n), .start(start), .wr_data(wr_data),
    .rd_data(rd_data), .busy(busy), .done(done), .sclk(sclk),
    .sync_n(sync_n), .sdin(sdin), .sdo(sdo), .ldac_n(ldac_n));

  // chain of devices: device 0 fed by sdin, device N-1 drives sdo
  logic [W-1:0] sr [N];
  logic [W-1:0] dreg [N];
  assign sdo = sr[N-1][W-1];

  always @(negedge sync_n)
    for (int d = 0; d < N; d++) sr[d] <= dreg[d];
  always @(negedge sclk)
    if (!sync_n)
      for (int d = 0; d < N; d++)
        sr[d] <= {sr[d][W-2:0], (d == 0) ? sdin : sr[d-1][W-1]};
  always @(negedge ldac_n)
    for (int d = 0; d < N; d++) dreg[d] <= sr[d];

  // monitors
  int falls, lcnt, gcnt, viol, ldac_edges;
  logic p_sclk = 1'b1, p_sdin = 1'b0, p_ldac = 1'b1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (p_sclk && !sclk && !sync_n) falls++;
      if (!ldac_n) lcnt++;
      if (sync_n && busy && ldac_n) gcnt++;
      if (p_ldac && !ldac_n) ldac_edges++;
      if (!sclk && !p_sclk && sdin !== p_sdin) viol++;
    end
    p_sclk = sclk; p_sdin = sdin; p_ldac = ldac_n;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] word_of(input logic [TOT-1:0] v, input int i);
    return v[i*W +: W];
  endfunction

  logic [W-1:0] expdev [N];

  task automatic run(input logic [TOT-1:0] data, input bit poke);
    int t;
    falls = 0; lcnt = 0; gcnt = 0; viol = 0; ldac_edges = 0;
    @(negedge clk); wr_data = data; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy === 1'b1, "R8 busy after start", 64'(busy), 64'd1);
    if (poke) begin
      repeat (40) @(negedge clk);
      wr_data = ~data; start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk(busy === 1'b1, "R9 busy kept on ignored start", 64'(busy), 64'd1);
    end
    t = 0;
    while (done !== 1'b1 && t < 3000) begin @(negedge clk); t++; end
    chk(t < 3000, "R8 done seen", 64'(t), 64'd0);
    chk(busy === 1'b0 && ldac_n === 1'b1, "R8 busy low with done", 64'({busy, ldac_n}), 64'b01);
    chk(falls == TOT, "R2 falling edge count", 64'(falls), 64'(TOT));
    chk(viol == 0, "R4 sdin moved while sclk low", 64'(viol), 64'd0);
    chk(lcnt == 4*DIV && ldac_edges == 1, "R7 ldac width", 64'(lcnt), 64'(4*DIV));
    chk(gcnt >= 4*DIV, "R6 sync-high gap", 64'(gcnt), 64'(4*DIV));
    for (int i = 0; i < N; i++) begin
      chk(word_of(rd_data, i) === expdev[i], "R5 readback word", 64'(word_of(rd_data, i)), 64'(expdev[i]));
      chk(dreg[i] === word_of(data, i), "R3 device content", 64'(dreg[i]), 64'(word_of(data, i)));
      expdev[i] = word_of(data, i);
    end
    @(negedge clk); @(negedge clk);
    chk(busy === 1'b0 && sync_n === 1'b1, "R9 no second burst", 64'({busy, sync_n}), 64'b01);
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    for (int d = 0; d < N; d++) begin
      dreg[d] = 16'h1357 * 16'(d + 1) ^ 16'hA5C3;
      sr[d] = '0;
      expdev[d] = dreg[d];
    end
    repeat (3) @(negedge clk);
    chk(sync_n === 1 && ldac_n === 1 && sclk === 1 && busy === 0 && done === 0,
        "R1 reset state", 64'({sync_n, ldac_n, sclk, busy, done}), 64'b11100);
    rst_n = 1'b1;
    @(negedge clk);
    run({TOT{1'b0}}, 1'b0);
    run({TOT{1'b1}}, 1'b0);
    run({N{16'h8001}}, 1'b0);
    run({16'hDEAD, 16'hBEEF, 16'h0F0F}, 1'b1);
    for (int k = 0; k < 15; k++) begin
      logic [TOT-1:0] v;
      for (int i = 0; i < N; i++) v[i*W +: W] = 16'($urandom);
      run(v, (k % 5) == 2);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule